// File: doc/BRIEF.md
# Command Register Handshake Engine

This block sits between a host and a communication co-processor and presents one 16-bit command register. To issue a command, the host writes an opcode, a channel number and a busy flag in a single write. It may also set a restart bit. The engine checks the written value. If the value is well formed and no command is pending, the engine sends the opcode and channel to a back-end executor as a single-cycle start pulse. When the executor finishes, the engine drops the busy flag. The host polls that flag to learn when the co-processor will take another command.

A command with the restart bit set is not sent to the executor. Instead it drives a co-processor restart line for a fixed number of cycles, and the flag drops when the restart ends. The executor here is a simple model with a set latency that stands in for the real channel logic. What each opcode does is outside this block. Every read returns the live flag together with the fields of the last command the engine accepted.

Top module: `cmdreg_engine`

## Requirements
- R1: On synchronous reset, host_rdata reads 0x0000, and exec_start, exec_done and cp_restart are low.
- R2: A write while idle whose bit 0 is 1, whose bit 15 is 0 and whose reserved bits (14:12 and 3:1) are all 0 is accepted. In the next cycle exec_start is high for exactly one cycle, with exec_opcode equal to bits 11:8 and exec_chan equal to bits 7:4.
- R3: For an accepted normal command, exec_done pulses LATENCY+1 cycles after exec_start. host_rdata bit 0 reads 1 for exactly LATENCY+2 cycles, counted from the cycle after the write edge.
- R4: Once a command has been accepted, host_rdata bits 15, 11:8 and 7:4 return that command's restart bit, opcode and channel. All other bits except bit 0 read 0.
- R5: A write that arrives while bit 0 of host_rdata is 1 is ignored. It raises no start pulse, changes no field and does not change when the current command completes.
- R6: A write with bit 0 equal to 0 is ignored and leaves the engine idle.
- R7: A write with any reserved bit set (bits 14:12 or 3:1) is ignored and leaves the engine idle.
- R8: An accepted write with bits 15 and 0 both set raises no exec_start. It holds cp_restart high for RESET_CYCLES cycles, starting in the second busy cycle. The flag reads 1 for RESET_CYCLES+2 cycles, and cp_restart is never high while the flag is 0.
- R9: The flag of any accepted command clears in fewer than POLL_LIMIT (10000) cycles, so a host polling loop bounded at 10000 reads always sees the command complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for the command register |
| host_wdata | input | 16 | Value written to the command register |
| host_rdata | output | 16 | Live flag in bit 0 plus the last accepted command fields |
| exec_start | output | 1 | One-cycle start pulse to the executor |
| exec_opcode | output | 4 | Opcode of the current command |
| exec_chan | output | 4 | Channel number of the current command |
| exec_done | output | 1 | One-cycle completion pulse from the executor model |
| cp_restart | output | 1 | Co-processor restart line driven by the restart command |

## Verification
The bound checker checks these rules on every cycle:
- exec_start is a single-cycle pulse.
- No start pulse follows a write made while busy, or a write made with the flag bit clear.
- The command fields stay stable while a command is busy.
- The restart line never rises outside a busy interval and never coincides with a start pulse.
- No busy interval reaches the polling bound.

Only the bench scenarios can show the following:
- The exact busy lengths for normal and restart commands.
- The decoded opcode and channel values.
- The read-back value after each completion.
- That rejected writes with reserved bits set leave the previous fields in place.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  localparam int REG_W    = 16;
  localparam int OP_W     = 4;
  localparam int CH_W     = 4;
  localparam int OP_LSB   = 8;
  localparam int CH_LSB   = 4;
  localparam int FLAG_BIT = 0;
  localparam int RST_BIT  = 15;
  localparam logic [REG_W-1:0] RSVD_MASK = 16'h700E;

  typedef struct packed {
    logic            restart;
    logic [OP_W-1:0] op;
    logic [CH_W-1:0] ch;
  } cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EXEC  = 2'd1,
    ST_RESET = 2'd2
  } eng_state_e;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmdreg_pkg::*;
(
  input  logic [REG_W-1:0] wdata,
  output cmd_t             cmd,
  output logic             well_formed
);
  always_comb begin
    cmd.restart = wdata[RST_BIT];
    cmd.op      = wdata[OP_LSB +: OP_W];
    cmd.ch      = wdata[CH_LSB +: CH_W];
    well_formed = wdata[FLAG_BIT] && ((wdata & RSVD_MASK) == '0);
  end
endmodule

// File: rtl/cmd_ctrl.sv
module cmd_ctrl
  import cmdreg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic dec_ok,
  input  cmd_t dec_cmd,
  input  logic exec_done,
  input  logic restart_done,
  output cmd_t cmd_q,
  output logic busy,
  output logic start_pulse,
  output logic restart_req
);
  eng_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cmd_q       <= '0;
      start_pulse <= 1'b0;
      restart_req <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      restart_req <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (wr && dec_ok) begin
            cmd_q <= dec_cmd;
            if (dec_cmd.restart) begin
              st          <= ST_RESET;
              restart_req <= 1'b1;
            end else begin
              st          <= ST_EXEC;
              start_pulse <= 1'b1;
            end
          end
        end
        ST_EXEC:  if (exec_done)    st <= ST_IDLE;
        ST_RESET: if (restart_done) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/exec_model.sv
module exec_model #(
  parameter int LATENCY = 5,
  localparam int CW = $clog2(LATENCY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (start) begin
      cnt  <= CW'(LATENCY);
      done <= 1'b0;
    end else if (cnt != '0) begin
      cnt  <= cnt - 1'b1;
      done <= (cnt == CW'(1));
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/restart_seq.sv
module restart_seq #(
  parameter int RESET_CYCLES = 8,
  localparam int CW = $clog2(RESET_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic cp_restart,
  output logic done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      cp_restart <= 1'b0;
      done       <= 1'b0;
    end else if (req) begin
      cnt        <= CW'(RESET_CYCLES);
      cp_restart <= 1'b1;
      done       <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        cp_restart <= 1'b0;
        done       <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/cmdreg_engine.sv
module cmdreg_engine
  import cmdreg_pkg::*;
#(
  parameter int LATENCY      = 5,
  parameter int RESET_CYCLES = 8,
  parameter int POLL_LIMIT   = 10000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  output logic             exec_start,
  output logic [OP_W-1:0]  exec_opcode,
  output logic [CH_W-1:0]  exec_chan,
  output logic             exec_done,
  output logic             cp_restart
);
  cmd_t dec_cmd, cmd_q;
  logic dec_ok, busy, restart_req, restart_done;

  cmd_decode u_dec (
    .wdata       (host_wdata),
    .cmd         (dec_cmd),
    .well_formed (dec_ok)
  );

  cmd_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .wr           (host_wr),
    .dec_ok       (dec_ok),
    .dec_cmd      (dec_cmd),
    .exec_done    (exec_done),
    .restart_done (restart_done),
    .cmd_q        (cmd_q),
    .busy         (busy),
    .start_pulse  (exec_start),
    .restart_req  (restart_req)
  );

  exec_model #(.LATENCY(LATENCY)) u_exec (
    .clk   (clk),
    .rst   (rst || cp_restart),
    .start (exec_start),
    .done  (exec_done)
  );

  restart_seq #(.RESET_CYCLES(RESET_CYCLES)) u_rseq (
    .clk        (clk),
    .rst        (rst),
    .req        (restart_req),
    .cp_restart (cp_restart),
    .done       (restart_done)
  );

  always_comb begin
    host_rdata                  = '0;
    host_rdata[RST_BIT]         = cmd_q.restart;
    host_rdata[OP_LSB +: OP_W]  = cmd_q.op;
    host_rdata[CH_LSB +: CH_W]  = cmd_q.ch;
    host_rdata[FLAG_BIT]        = busy;
  end

  assign exec_opcode = cmd_q.op;
  assign exec_chan   = cmd_q.ch;
endmodule

// File: rtl/cmdreg_engine_chk.sv
module cmdreg_engine_chk #(
  parameter int POLL_LIMIT = 10000,
  localparam int PW = $clog2(POLL_LIMIT + 1)
) (
  input logic        clk,
  input logic        rst,
  input logic        host_wr,
  input logic [15:0] host_wdata,
  input logic [15:0] host_rdata,
  input logic        exec_start,
  input logic        cp_restart
);
  logic [PW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst || !host_rdata[0]) busy_run <= '0;
    else if (busy_run != PW'(POLL_LIMIT)) busy_run <= busy_run + 1'b1;
  end

  p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
    exec_start |=> !exec_start);

  p_busy_write_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (host_rdata[0] && host_wr) |=> !exec_start);

  p_fields_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (host_rdata[0] && $past(host_rdata[0])) |-> $stable(host_rdata[15:4]));

  p_noflag_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (!host_rdata[0] && host_wr && !host_wdata[0]) |=> (!host_rdata[0] && !exec_start));

  p_restart_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
    cp_restart |-> (host_rdata[0] && !exec_start));

  p_poll_bound_r9: assert property (@(posedge clk) disable iff (rst)
    busy_run < PW'(POLL_LIMIT));
endmodule

bind cmdreg_engine cmdreg_engine_chk #(.POLL_LIMIT(POLL_LIMIT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .exec_start (exec_start),
  .cp_restart (cp_restart)
);

// File: tb/cmdreg_engine_tb.sv
module cmdreg_engine_tb;
  localparam int LAT  = 5;
  localparam int RCYC = 8;
  localparam int NV   = 8;
  // {wdata, accepted, restart}
  localparam logic [17:0] VEC [NV] = '{
    {16'h0351, 1'b1, 1'b0},
    {16'h0A01, 1'b1, 1'b0},
    {16'h0FF1, 1'b1, 1'b0},
    {16'h0720, 1'b0, 1'b0},
    {16'h2461, 1'b0, 1'b0},
    {16'h0465, 1'b0, 1'b0},
    {16'h8C31, 1'b1, 1'b1},
    {16'h0B71, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, host_wr = 1'b0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic exec_start, exec_done, cp_restart;
  logic [3:0] exec_opcode, exec_chan;
  int tests = 0, fails = 0, starts = 0, cycles = 0;

  always #2.5 clk = ~clk;

  cmdreg_engine #(.LATENCY(LAT), .RESET_CYCLES(RCYC), .POLL_LIMIT(10000)) u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .exec_start(exec_start), .exec_opcode(exec_opcode),
    .exec_chan(exec_chan), .exec_done(exec_done), .cp_restart(cp_restart)
  );

  always @(negedge clk) if (exec_start) starts++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] w);
    @(negedge clk); host_wr = 1'b1; host_wdata = w;
    @(negedge clk); host_wr = 1'b0; host_wdata = '0;
  endtask

  // counts flag-high cycles starting at the current negedge
  task automatic count_busy(output int n, output int rc);
    n = 0; rc = 0;
    while (host_rdata[0] && n < 10000) begin
      n++;
      if (cp_restart) rc++;
      @(negedge clk);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] prev;
    int n, rc, s0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(host_rdata == 16'h0 && !exec_start && !exec_done && !cp_restart,
          "R1", host_rdata, 0);
    prev = 16'h0;

    for (int i = 0; i < NV; i++) begin
      logic [15:0] w; logic acc, rs;
      {w, acc, rs} = VEC[i];
      s0 = starts;
      do_write(w);
      if (acc && !rs)
        check(exec_start && exec_opcode == w[11:8] && exec_chan == w[7:4],
              "R2", {exec_start, exec_opcode, exec_chan}, {1'b1, w[11:8], w[7:4]});
      if (rs) check(!exec_start, "R8", exec_start, 0);
      count_busy(n, rc);
      if (!acc) check(n == 0, (w[0] ? "R7" : "R6"), n, 0);
      else if (rs) begin
        check(n == RCYC + 2, "R8", n, RCYC + 2);
        check(rc == RCYC, "R8", rc, RCYC);
      end else check(n == LAT + 2, "R3", n, LAT + 2);
      if (acc) check(n < 10000, "R9", n, 10000);
      check(starts - s0 == ((acc && !rs) ? 1 : 0), "R2", starts - s0, (acc && !rs) ? 1 : 0);
      if (acc) prev = w & 16'h8FF0;
      check(host_rdata == prev, acc ? "R4" : "R7", host_rdata, prev);
    end

    // R5: write during busy is ignored
    s0 = starts;
    do_write(16'h0351);
    @(negedge clk) ; // second busy cycle
    host_wr = 1'b1; host_wdata = 16'h0E91;
    @(negedge clk); host_wr = 1'b0; host_wdata = '0;
    count_busy(n, rc);
    check(n == LAT, "R5", n + 2, LAT + 2);
    check(starts - s0 == 1, "R5", starts - s0, 1);
    check(host_rdata == 16'h0350, "R5", host_rdata, 16'h0350);

    // R1: reset in the middle of a command
    do_write(16'h0C21);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(host_rdata == 16'h0 && !cp_restart && !exec_start, "R1", host_rdata, 0);
    repeat (LAT + 3) @(negedge clk);
    check(!exec_done && host_rdata == 16'h0, "R1", host_rdata, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule